// File: doc/BRIEF.md
# Reference Clock Qualification Monitor

The block watches one reference clock input from the master clock domain and decides, continuously and independently of whether any selector downstream is using it, whether that input can be trusted. Two verdicts are kept. A fast activity verdict drops within a few expected input periods once edges stop arriving. A slower frequency verdict comes from counting input edges over a fixed gate of master-clock cycles and comparing the count with a programmed nominal value.

The input is brought into the master domain by a two-flop synchronizer, and its rising edges are detected there. The activity path counts master cycles between edges. Each time a full programmed period passes without an edge, it scores a missed period, and it disqualifies the input after a programmed number of consecutive misses. It requalifies only after a programmed run of consecutive good edges. The frequency path reports the signed difference between the edge count and the nominal count. It applies separate accept and reject limits to the size of that difference, so the in-range verdict has hysteresis. One count step equals one part in the nominal count. With a gate and nominal of 5,000,000 the step is 0.2 ppm.

All limits sit in six small registers written through a simple address/data write port. This lets each monitor instance carry its own thresholds.

Top module: `clkqual_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `ref_active` and `freq_in_range` are 0 and `freq_offset` is 0. The registers take their parameter defaults.
- R2: The input is sampled by two master-clock flops, and only a 0-to-1 change counts as an edge. An input rise that is sampled at master edge k is acted on at master edge k+2.
- R3: A gap counter restarts on every edge. When it has counted PERIOD master cycles (register 3) with no edge, one missed period is scored and the counter restarts. `ref_active` clears on the edge at which the consecutive miss count reaches MISS (register 4).
- R4: While inactive, each edge adds one to a good count, and `ref_active` sets on the edge at which that count reaches GOOD (register 5). A missed period clears the good count.
- R5: The gate is GATE_LEN master cycles long, starting when reset ends. On the cycle after each gate ends, `freq_offset` becomes (edges in gate − NOMINAL (register 0)) as a two's-complement signed value. It is otherwise unchanged.
- R6: When a gate ends with the flag at 1 and |offset| > REJECT (register 2), `freq_in_range` clears.
- R7: When a gate ends with the flag at 0 and |offset| ≤ ACCEPT (register 1), `freq_in_range` sets. In every other case the flag keeps its value, which gives hysteresis between the two limits.
- R8: A write with `cfg_we` high loads `cfg_wdata` (truncated to the field width) into the register at `cfg_addr` 0 to 5. Addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_in | input | 1 | Monitored reference clock, asynchronous to clk |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address: 0 nominal, 1 accept, 2 reject, 3 period, 4 miss limit, 5 good limit |
| cfg_wdata | input | CNT_W | Register write data |
| ref_active | output | 1 | Activity verdict, 1 = edges arriving |
| freq_in_range | output | 1 | Frequency verdict, 1 = within limits |
| freq_offset | output | CNT_W+1 | Signed edge-count difference from nominal of the last gate |

## Verification
An input rise sampled at master edge k reaches the edge detector two edges later. The activity verdict therefore moves on edge k+2 after the deciding input rise, or on the edge where the gap counter completes the last allowed missed period. The offset and the in-range flag move only on the edge that closes a gate, which is edge GATE_LEN, 2·GATE_LEN and so on after reset. The bench model advances on the same rising edges, using the same sampled input and registered configuration. All three outputs are compared with the model on every falling edge, so a result that arrives a cycle early or late is caught. Named checks at chosen points cover the hysteresis, disqualification, requalification and unmapped-write cases.

// File: rtl/clkqual_pkg.sv
package clkqual_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_NOMINAL = 3'd0,
    REG_ACCEPT  = 3'd1,
    REG_REJECT  = 3'd2,
    REG_PERIOD  = 3'd3,
    REG_MISS    = 3'd4,
    REG_GOOD    = 3'd5
  } cfg_reg_e;
endpackage

// File: rtl/clkqual_sync_edge.sv
module clkqual_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  // rising edge on the last two synchronised stages
  assign edge_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  a_r2_edge_rises: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/clkqual_cfg_regs.sv
module clkqual_cfg_regs
  import clkqual_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int GAP_W       = 16,
  parameter int LIM_W       = 4,
  parameter int DEF_NOMINAL = 5000000,
  parameter int DEF_ACCEPT  = 2,
  parameter int DEF_REJECT  = 4,
  parameter int DEF_PERIOD  = 400,
  parameter int DEF_MISS    = 3,
  parameter int DEF_GOOD    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  nominal_o,
  output logic [CNT_W-1:0]  accept_o,
  output logic [CNT_W-1:0]  reject_o,
  output logic [GAP_W-1:0]  period_o,
  output logic [LIM_W-1:0]  miss_o,
  output logic [LIM_W-1:0]  good_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nominal_o <= CNT_W'(DEF_NOMINAL);
      accept_o  <= CNT_W'(DEF_ACCEPT);
      reject_o  <= CNT_W'(DEF_REJECT);
      period_o  <= GAP_W'(DEF_PERIOD);
      miss_o    <= LIM_W'(DEF_MISS);
      good_o    <= LIM_W'(DEF_GOOD);
    end else if (we_i) begin
      case (addr_i)
        REG_NOMINAL: nominal_o <= wdata_i;
        REG_ACCEPT:  accept_o  <= wdata_i;
        REG_REJECT:  reject_o  <= wdata_i;
        REG_PERIOD:  period_o  <= wdata_i[GAP_W-1:0];
        REG_MISS:    miss_o    <= wdata_i[LIM_W-1:0];
        REG_GOOD:    good_o    <= wdata_i[LIM_W-1:0];
        default: ;
      endcase
    end
  end

  a_r8_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i > REG_GOOD) |=>
      ($stable(nominal_o) && $stable(accept_o) && $stable(reject_o) &&
       $stable(period_o) && $stable(miss_o) && $stable(good_o)));
endmodule

// File: rtl/clkqual_activity.sv
module clkqual_activity #(
  parameter int GAP_W = 16,
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic [GAP_W-1:0] period_i,
  input  logic [LIM_W-1:0] miss_lim_i,
  input  logic [LIM_W-1:0] good_lim_i,
  output logic             active_o
);
  localparam int LX_W = LIM_W + 1;

  logic [GAP_W-1:0] gap_q;
  logic [LIM_W-1:0] miss_q, good_q;
  logic             act_q;
  logic             period_done;
  logic [LX_W-1:0]  miss_next, good_next;

  assign period_done = (gap_q >= period_i - GAP_W'(1));
  assign miss_next   = {1'b0, miss_q} + LX_W'(1);
  assign good_next   = {1'b0, good_q} + LX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      miss_q <= '0;
      good_q <= '0;
      act_q  <= 1'b0;
    end else if (edge_i) begin
      gap_q  <= '0;
      miss_q <= '0;
      if (!act_q) begin
        if (good_next >= {1'b0, good_lim_i}) begin
          act_q  <= 1'b1;
          good_q <= '0;
        end else begin
          good_q <= good_next[LIM_W-1:0];
        end
      end
    end else if (period_done) begin
      gap_q  <= '0;
      good_q <= '0;
      if (miss_next >= {1'b0, miss_lim_i}) act_q  <= 1'b0;
      else                                 miss_q <= miss_next[LIM_W-1:0];
    end else begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  assign active_o = act_q;

  a_r4_rise_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> $past(edge_i));
  a_r3_fall_without_edge: assert property (@(posedge clk) disable iff (rst)
    $fell(act_q) |-> !$past(edge_i));
  a_r3_edge_keeps_active: assert property (@(posedge clk) disable iff (rst)
    (edge_i && act_q) |=> act_q);
endmodule

// File: rtl/clkqual_freq.sv
module clkqual_freq #(
  parameter int CNT_W    = 24,
  parameter int GATE_LEN = 5000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] nominal_i,
  input  logic [CNT_W-1:0] accept_i,
  input  logic [CNT_W-1:0] reject_i,
  output logic             in_range_o,
  output logic [CNT_W:0]   offset_o
);
  localparam int OW     = CNT_W + 1;
  localparam int GATE_W = (GATE_LEN > 2) ? $clog2(GATE_LEN) : 1;
  localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_LEN - 1);

  logic [GATE_W-1:0] gate_q;
  logic [CNT_W-1:0]  edges_q, edges_total;
  logic              gate_end;
  logic signed [OW-1:0] diff, mag, off_q, off_mag;
  logic              inr_q;

  assign gate_end    = (gate_q == GATE_LAST);
  assign edges_total = edges_q + CNT_W'(edge_i);
  assign diff        = $signed({1'b0, edges_total}) - $signed({1'b0, nominal_i});
  assign mag         = diff[OW-1] ? -diff : diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= '0;
      edges_q <= '0;
      off_q   <= '0;
      inr_q   <= 1'b0;
    end else if (gate_end) begin
      gate_q  <= '0;
      edges_q <= '0;
      off_q   <= diff;
      if (inr_q && (mag > $signed({1'b0, reject_i})))       inr_q <= 1'b0;
      else if (!inr_q && (mag <= $signed({1'b0, accept_i}))) inr_q <= 1'b1;
    end else begin
      gate_q  <= gate_q + GATE_W'(1);
      edges_q <= edges_total;
    end
  end

  assign in_range_o = inr_q;
  assign offset_o   = off_q;
  assign off_mag    = off_q[OW-1] ? -off_q : off_q;

  a_r7_set_within_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(inr_q) |-> (off_mag <= $signed({1'b0, $past(accept_i)})));
  a_r6_clear_beyond_reject: assert property (@(posedge clk) disable iff (rst)
    $fell(inr_q) |-> (off_mag > $signed({1'b0, $past(reject_i)})));
  a_r5_offset_only_at_gate: assert property (@(posedge clk) disable iff (rst)
    !$past(gate_end) |-> ($stable(off_q) && $stable(inr_q)));
endmodule

// File: rtl/clkqual_monitor.sv
module clkqual_monitor
  import clkqual_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int GATE_LEN    = 5000000,
  parameter int GAP_W       = 16,
  parameter int LIM_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_NOMINAL = 5000000,
  parameter int DEF_ACCEPT  = 2,
  parameter int DEF_REJECT  = 4,
  parameter int DEF_PERIOD  = 400,
  parameter int DEF_MISS    = 3,
  parameter int DEF_GOOD    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk_in,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              ref_active,
  output logic              freq_in_range,
  output logic [CNT_W:0]    freq_offset
);
  logic             ref_edge;
  logic [CNT_W-1:0] nominal, accept, reject;
  logic [GAP_W-1:0] period;
  logic [LIM_W-1:0] miss_lim, good_lim;

  clkqual_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(ref_clk_in), .edge_o(ref_edge));

  clkqual_cfg_regs #(
    .CNT_W(CNT_W), .GAP_W(GAP_W), .LIM_W(LIM_W),
    .DEF_NOMINAL(DEF_NOMINAL), .DEF_ACCEPT(DEF_ACCEPT), .DEF_REJECT(DEF_REJECT),
    .DEF_PERIOD(DEF_PERIOD), .DEF_MISS(DEF_MISS), .DEF_GOOD(DEF_GOOD)
  ) u_regs (
    .clk(clk), .rst(rst), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
    .nominal_o(nominal), .accept_o(accept), .reject_o(reject),
    .period_o(period), .miss_o(miss_lim), .good_o(good_lim));

  clkqual_activity #(.GAP_W(GAP_W), .LIM_W(LIM_W)) u_act (
    .clk(clk), .rst(rst), .edge_i(ref_edge), .period_i(period),
    .miss_lim_i(miss_lim), .good_lim_i(good_lim), .active_o(ref_active));

  clkqual_freq #(.CNT_W(CNT_W), .GATE_LEN(GATE_LEN)) u_freq (
    .clk(clk), .rst(rst), .edge_i(ref_edge), .nominal_i(nominal),
    .accept_i(accept), .reject_i(reject),
    .in_range_o(freq_in_range), .offset_o(freq_offset));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ref_active && !freq_in_range && freq_offset == '0));
endmodule

// File: tb/clkqual_monitor_tb.sv
module clkqual_monitor_tb_top;
  localparam int CNT_W = 24;
  localparam int GATE  = 200;
  localparam int GAP_W = 16;
  localparam int LIM_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [CNT_W-1:0] cfg_wdata = '0;
  logic ref_active, freq_in_range;
  logic [CNT_W:0] freq_offset;

  int errors = 0, checks = 0;
  bit started = 0;

  always #4 clk = ~clk;

  clkqual_monitor #(
    .CNT_W(CNT_W), .GATE_LEN(GATE), .GAP_W(GAP_W), .LIM_W(LIM_W),
    .DEF_NOMINAL(25), .DEF_ACCEPT(1), .DEF_REJECT(3),
    .DEF_PERIOD(12), .DEF_MISS(3), .DEF_GOOD(4)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_clk_in(ref_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ref_active(ref_active),
    .freq_in_range(freq_in_range), .freq_offset(freq_offset));

  // behavioural reference model
  int m_nom, m_acc, m_rej, m_per, m_miss_lim, m_good_lim;
  int m_gap, m_miss, m_good, m_gcnt, m_ecnt, m_off;
  bit m_act, m_inr;
  bit smp[$];

  always @(posedge clk) begin
    if (rst) begin
      m_nom = 25; m_acc = 1; m_rej = 3; m_per = 12; m_miss_lim = 3; m_good_lim = 4;
      m_gap = 0; m_miss = 0; m_good = 0; m_gcnt = 0; m_ecnt = 0; m_off = 0;
      m_act = 0; m_inr = 0;
      smp = '{0, 0, 0};
    end else begin
      bit e;
      int tot, mg;
      e = smp[1] && !smp[2];
      if (e) begin
        m_gap = 0; m_miss = 0;
        if (!m_act) begin
          if (m_good + 1 >= m_good_lim) begin m_act = 1; m_good = 0; end
          else m_good++;
        end
      end else if (m_gap >= ((m_per - 1) & 16'hFFFF)) begin
        m_gap = 0; m_good = 0;
        if (m_miss + 1 >= m_miss_lim) m_act = 0;
        else m_miss++;
      end else m_gap++;
      tot = m_ecnt + int'(e);
      if (m_gcnt == GATE - 1) begin
        m_gcnt = 0; m_ecnt = 0; m_off = tot - m_nom;
        mg = (m_off < 0) ? -m_off : m_off;
        if (m_inr && mg > m_rej) m_inr = 0;
        else if (!m_inr && mg <= m_acc) m_inr = 1;
      end else begin m_gcnt++; m_ecnt = tot; end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_nom = int'(cfg_wdata);
          3'd1: m_acc = int'(cfg_wdata);
          3'd2: m_rej = int'(cfg_wdata);
          3'd3: m_per = int'(cfg_wdata[GAP_W-1:0]);
          3'd4: m_miss_lim = int'(cfg_wdata[LIM_W-1:0]);
          3'd5: m_good_lim = int'(cfg_wdata[LIM_W-1:0]);
          default: ;
        endcase
      end
      smp.push_front(ref_in);
      void'(smp.pop_back());
      started = 1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (started && !rst) begin
      check("R3/R4 ref_active", int'(ref_active), int'(m_act));
      check("R6/R7 freq_in_range", int'(freq_in_range), int'(m_inr));
      check("R5 freq_offset", int'($signed(freq_offset)), m_off);
    end
  end

  task automatic run(int hi, int lo, int cycles);
    int ph = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (hi == 0) ref_in = 1'b0;
      else begin
        ref_in = (ph < hi);
        ph = (ph + 1 == hi + lo) ? 0 : ph + 1;
      end
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = CNT_W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values while reset is held
    check("R1 active in reset", int'(ref_active), 0);
    check("R1 in_range in reset", int'(freq_in_range), 0);
    check("R1 offset in reset", int'(freq_offset), 0);
    rst = 1'b0;
    // R2/R4: period-8 input qualifies after good edges
    run(4, 4, 600);
    check("R4 active after good edges", int'(ref_active), 1);
    check("R7 in range at nominal", int'(freq_in_range), 1);
    // R3: stopped input
    run(0, 0, 20);
    check("R3 still active inside miss window", int'(ref_active), 1);
    run(0, 0, 40);
    check("R3 dropped after missed periods", int'(ref_active), 0);
    // R4: requalify
    run(4, 4, 500);
    check("R4 requalified", int'(ref_active), 1);
    check("R7 back in range", int'(freq_in_range), 1);
    // R6: fast input, offset +8
    run(3, 3, 450);
    check("R6 cleared beyond reject", int'(freq_in_range), 0);
    check("R5 offset of fast input", int'($signed(freq_offset)), 8);
    // R7: offset between accept and reject keeps flag low
    run(3, 4, 450);
    check("R7 hysteresis holds low", int'(freq_in_range), 0);
    run(4, 4, 450);
    check("R7 set within accept", int'(freq_in_range), 1);
    // R7: offset -2 within reject holds high
    wr(0, 27);
    run(4, 4, 450);
    check("R7 hysteresis holds high", int'(freq_in_range), 1);
    check("R5 offset negative", int'($signed(freq_offset)), -2);
    wr(0, 30);
    run(4, 4, 450);
    check("R6 cleared by nominal change", int'(freq_in_range), 0);
    // R8: unmapped writes do not alias onto reject
    wr(0, 25);
    run(4, 4, 450);
    wr(6, 1);
    wr(7, 1);
    wr(0, 27);
    run(4, 4, 450);
    check("R8 unmapped write ignored", int'(freq_in_range), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule